// File: doc/BRIEF.md
# Multiplexed Multi-Channel Moving-Average Load Summer

This block takes one sample from each of eight analog channels once per sample period, keeps a moving average over the last 256 samples of every channel, and multiplies each average by a gain word that the host writes. It then adds the scaled channels into one total and holds that total in a register for the analog output stage further down the path. The sample period is 800 clocks of a 40 MHz clock, which gives 50 kHz per channel.

A single accumulate-and-subtract engine serves the channels in turn. All channels share one sample memory, split into one circular region per channel. Each channel's running sum is updated as sum + newest - oldest. The divide by the window length is an arithmetic shift, and the conversion to engineering units is a multiply by a host-supplied reciprocal. The eight scaled values go into a balanced adder tree, and the result is saturated to the output width.

The host loads the gains once, after calibration. A gain write takes effect at the next update of the total. Running sums start from zero after reset. The output therefore ramps up until a full window of sample sets has arrived, and a valid flag then rises and stays high.

Top module: `ldsum_top`

## Requirements
- R1: After reset, `total` is 0, `total_done` is 0, `avg_valid` is 0 and every gain is 0.
- R2: At every update, the average of a channel is floor(S / 2^LOG_WIN). S is the sum of that channel's last 2^LOG_WIN samples, and a sample that has not yet arrived counts as zero. Channel c is read from `smp_data[c*SW +: SW]` as a two's-complement value when `smp_strobe` is high.
- R3: The scaled value of a channel is floor(avg * g / 2^GFRAC). Here g is that channel's gain, read as an unsigned integer.
- R4: `total` is the sum of all scaled channel values, read as two's complement and saturated to the range of a signed OW-bit number.
- R5: Each accepted `smp_strobe` produces exactly one `total_done` pulse, one cycle long, no later than 2*NCH+4 clock cycles after the strobe cycle. `total` updates in the same cycle as that pulse.
- R6: `total` does not change in any cycle in which `total_done` is low.
- R7: `avg_valid` is low until 2^LOG_WIN sample sets have been processed. It rises with the done pulse of that set and stays high until the next reset.
- R8: A write with `gain_we` high stores `gain_wdata` as the gain of channel `gain_addr`. The new gain has no effect on `total` before the next done pulse, and it applies from that update on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_strobe | input | 1 | One-cycle pulse: a new set of channel samples is present |
| smp_data | input | NCH*SW | Packed channel samples, channel c at bits c*SW and up |
| gain_we | input | 1 | Gain write enable |
| gain_addr | input | $clog2(NCH) | Channel that the gain write selects |
| gain_wdata | input | GW | Unsigned fixed-point gain, GFRAC fraction bits |
| total | output | OW | Saturated signed total of the scaled channels |
| total_done | output | 1 | One-cycle pulse when `total` updates |
| avg_valid | output | 1 | A full window has filled for every channel |

## Verification
The bench keeps eight channels but shrinks the design. It sets LOG_WIN=2, so the window is four samples, and uses 12-bit samples, 16-bit running sums, 10-bit gains with 4 fraction bits and a 16-bit total. With a four-sample window, the bench can drive the ramp-up, the rise of the valid flag and many full window turnovers in a few dozen sample sets. The narrow total lets full-scale samples with large gains push the adder tree past both saturation limits. Every channel's gain is isolated in turn, and the bench also makes gain writes between updates to check that the total holds until the next done pulse.

// File: rtl/ldsum_pkg.sv
package ldsum_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_UPD  = 2'd2,
        ST_SUM  = 2'd3
    } eng_st_e;
endpackage

// File: rtl/ldsum_smp_mem.sv
module ldsum_smp_mem #(
    parameter int DW = 24,
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata_q
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        rdata_q <= mem[addr];
    end
endmodule

// File: rtl/ldsum_avg_engine.sv
module ldsum_avg_engine
    import ldsum_pkg::*;
#(
    parameter int NCH     = 8,
    parameter int SW      = 24,
    parameter int LOG_WIN = 8,
    parameter int SUMW    = 32,
    parameter int GW      = 18,
    parameter int GFRAC   = 16,
    localparam int CHW    = $clog2(NCH),
    localparam int SCW    = SW + GW + 1 - GFRAC
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_strobe,
    input  logic [NCH-1:0][SW-1:0]   smp_data,
    input  logic [NCH-1:0][GW-1:0]   gains,
    output logic [NCH-1:0][SCW-1:0]  scaled,
    output logic                     load,
    output logic                     full_next
);
    localparam int AW = CHW + LOG_WIN;
    localparam int PW = SW + GW + 1;
    localparam logic [LOG_WIN:0] WIN_C  = {1'b1, {LOG_WIN{1'b0}}};
    localparam logic [LOG_WIN:0] WIN_M1 = WIN_C - 1'b1;

    typedef struct packed {
        eng_st_e                   st;
        logic [CHW-1:0]            ch;
        logic [LOG_WIN-1:0]        wp;
        logic [LOG_WIN:0]          fill;
        logic [NCH-1:0][SW-1:0]    cap;
        logic [NCH-1:0][SUMW-1:0]  sums;
        logic [NCH-1:0][SCW-1:0]   scl;
    } eng_t;

    eng_t q, d;

    logic              mem_we;
    logic [AW-1:0]     mem_addr;
    logic [SW-1:0]     mem_rdata;
    logic signed [SW-1:0]   newv, oldv, avg;
    logic signed [SUMW-1:0] nsum;
    logic signed [PW-1:0]   prod;
    logic [GW:0]            gx;

    ldsum_smp_mem #(.DW(SW), .AW(AW)) u_mem (
        .clk     (clk),
        .we      (mem_we),
        .addr    (mem_addr),
        .wdata   (newv),
        .rdata_q (mem_rdata)
    );

    always_comb begin
        d        = q;
        mem_we   = 1'b0;
        mem_addr = {q.ch, q.wp};
        newv     = q.cap[q.ch];
        // entries not yet written since reset count as zero
        oldv     = (q.fill < WIN_C) ? '0 : mem_rdata;
        nsum     = q.sums[q.ch] + SUMW'(newv) - SUMW'(oldv);
        avg      = SW'(nsum >>> LOG_WIN);
        gx       = {1'b0, gains[q.ch]};
        prod     = PW'(avg) * $signed(PW'(gx));
        unique case (q.st)
            ST_IDLE: begin
                if (smp_strobe) begin
                    d.cap = smp_data;
                    d.ch  = '0;
                    d.st  = ST_RD;
                end
            end
            ST_RD: d.st = ST_UPD;
            ST_UPD: begin
                mem_we       = 1'b1;
                d.sums[q.ch] = nsum;
                d.scl[q.ch]  = SCW'(prod >>> GFRAC);
                if (q.ch == CHW'(NCH - 1)) begin
                    d.st = ST_SUM;
                end else begin
                    d.ch = q.ch + CHW'(1);
                    d.st = ST_RD;
                end
            end
            ST_SUM: begin
                d.wp = q.wp + LOG_WIN'(1);
                if (q.fill < WIN_C) d.fill = q.fill + (LOG_WIN+1)'(1);
                d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign scaled    = q.scl;
    assign load      = (q.st == ST_SUM);
    assign full_next = (q.fill >= WIN_M1);

    // R5
    upd_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_UPD) |-> ($past(q.st) == ST_RD));

    // R2
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.fill <= WIN_C);

    // R7
    fill_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.fill == WIN_C) |=> (q.fill == WIN_C));
endmodule

// File: rtl/ldsum_tree_out.sv
module ldsum_tree_out #(
    parameter int NCH = 8,
    parameter int SCW = 27,
    parameter int OW  = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic                     full_next,
    input  logic [NCH-1:0][SCW-1:0]  scaled,
    output logic [OW-1:0]            total_q,
    output logic                     done_q,
    output logic                     valid_q
);
    localparam int TW    = SCW + $clog2(NCH);
    localparam int NNODE = 2 * NCH - 1;

    logic signed [TW-1:0] node [NNODE];
    logic [OW-1:0]        sat;

    for (genvar i = 0; i < NCH; i++) begin : g_leaf
        assign node[NCH-1+i] = TW'($signed(scaled[i]));
    end
    for (genvar k = 0; k < NCH - 1; k++) begin : g_add
        assign node[k] = node[2*k+1] + node[2*k+2];
    end

    if (TW > OW) begin : g_sat
        logic [TW-OW:0] top;
        assign top = node[0][TW-1:OW-1];
        always_comb begin
            if ((top == '0) || (top == '1))
                sat = OW'(node[0]);
            else if (node[0][TW-1])
                sat = {1'b1, {(OW-1){1'b0}}};
            else
                sat = {1'b0, {(OW-1){1'b1}}};
        end
    end else begin : g_ext
        assign sat = OW'(node[0]);
    end

    typedef struct packed {
        logic [OW-1:0] total;
        logic          done;
        logic          valid;
    } out_t;

    out_t q, d;

    always_comb begin
        d      = q;
        d.done = load;
        if (load) begin
            d.total = sat;
            d.valid = q.valid | full_next;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign total_q = q.total;
    assign done_q  = q.done;
    assign valid_q = q.valid;

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R6
    total_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_q |-> $stable(total_q));

    // R7
    valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> valid_q);

    // R7
    valid_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_q) |-> done_q);
endmodule

// File: rtl/ldsum_top.sv
module ldsum_top #(
    parameter int NCH     = 8,
    parameter int SW      = 24,
    parameter int LOG_WIN = 8,
    parameter int SUMW    = 32,
    parameter int GW      = 18,
    parameter int GFRAC   = 16,
    parameter int OW      = 32,
    localparam int CHW    = $clog2(NCH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               smp_strobe,
    input  logic [NCH*SW-1:0]  smp_data,
    input  logic               gain_we,
    input  logic [CHW-1:0]     gain_addr,
    input  logic [GW-1:0]      gain_wdata,
    output logic [OW-1:0]      total,
    output logic               total_done,
    output logic               avg_valid
);
    localparam int SCW = SW + GW + 1 - GFRAC;

    logic [NCH-1:0][GW-1:0]  gain_d, gain_q;
    logic [NCH-1:0][SCW-1:0] scaled;
    logic                    load, full_next;

    always_comb begin
        gain_d = gain_q;
        if (gain_we && (int'(gain_addr) < NCH)) gain_d[gain_addr] = gain_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) gain_q <= '0;
        else        gain_q <= gain_d;
    end

    ldsum_avg_engine #(
        .NCH(NCH), .SW(SW), .LOG_WIN(LOG_WIN), .SUMW(SUMW),
        .GW(GW), .GFRAC(GFRAC)
    ) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_strobe(smp_strobe),
        .smp_data  (smp_data),
        .gains     (gain_q),
        .scaled    (scaled),
        .load      (load),
        .full_next (full_next)
    );

    ldsum_tree_out #(.NCH(NCH), .SCW(SCW), .OW(OW)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .full_next(full_next),
        .scaled   (scaled),
        .total_q  (total),
        .done_q   (total_done),
        .valid_q  (avg_valid)
    );

    // R8
    gain_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_we && (int'(gain_addr) < NCH)) |=> (gain_q[$past(gain_addr)] == $past(gain_wdata)));
endmodule

// File: tb/tb_ldsum_top.sv
module tb_ldsum_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH  = 8;
    localparam int SW   = 12;
    localparam int LW   = 2;
    localparam int WIN  = 1 << LW;
    localparam int SUMW = 16;
    localparam int GW   = 10;
    localparam int GF   = 4;
    localparam int OW   = 16;
    localparam int CHW  = $clog2(NCH);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              smp_strobe = 1'b0;
    logic [NCH*SW-1:0] smp_data = '0;
    logic              gain_we = 1'b0;
    logic [CHW-1:0]    gain_addr = '0;
    logic [GW-1:0]     gain_wdata = '0;
    logic [OW-1:0]     total;
    logic              total_done;
    logic              avg_valid;

    int checks = 0;
    int errors = 0;
    int hist [NCH][WIN];
    int bg [NCH];
    int wp = 0;
    int nsets = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ldsum_top #(.NCH(NCH), .SW(SW), .LOG_WIN(LW), .SUMW(SUMW),
                .GW(GW), .GFRAC(GF), .OW(OW)) dut (
        .clk(clk), .rst_n(rst_n), .smp_strobe(smp_strobe), .smp_data(smp_data),
        .gain_we(gain_we), .gain_addr(gain_addr), .gain_wdata(gain_wdata),
        .total(total), .total_done(total_done), .avg_valid(avg_valid)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint model_total();
        longint tot = 0;
        for (int c = 0; c < NCH; c++) begin
            longint s = 0;
            longint avg, sc;
            for (int j = 0; j < WIN; j++) s += hist[c][j];
            avg = s >>> LW;
            sc  = (avg * bg[c]) >>> GF;
            tot += sc;
        end
        if (tot > 32767) tot = 32767;
        if (tot < -32768) tot = -32768;
        return tot;
    endfunction

    task automatic write_gain(input int c, input int g);
        @(negedge clk);
        gain_we = 1'b1; gain_addr = CHW'(c); gain_wdata = GW'(g);
        @(negedge clk);
        gain_we = 1'b0;
        bg[c] = g;
    endtask

    task automatic run_set(input int vals [NCH], input string tag);
        int lat = 0;
        @(negedge clk);
        for (int c = 0; c < NCH; c++) smp_data[c*SW +: SW] = SW'(vals[c]);
        smp_strobe = 1'b1;
        for (int i = 1; i <= 2*NCH + 6; i++) begin
            @(negedge clk);
            if (i == 1) smp_strobe = 1'b0;
            if (total_done && lat == 0) begin
                lat = i;
                break;
            end
        end
        for (int c = 0; c < NCH; c++) hist[c][wp] = vals[c];
        wp = (wp + 1) % WIN;
        nsets++;
        // R5: pulse seen within the bound
        chk("R5 done latency in bound", (lat > 0 && lat <= 2*NCH + 4) ? 1 : 0, 1);
        chk({tag, " total"}, longint'($signed(total)), model_total());
        // R7
        chk("R7 valid flag", longint'(avg_valid), (nsets >= WIN) ? 1 : 0);
        @(negedge clk);
        // R5: single-cycle pulse
        chk("R5 done one cycle", longint'(total_done), 0);
    endtask

    function automatic int pat(input int kind, input int c, input int k);
        case (kind)
            0: return ((k * 73 + c * 311) * 17) % 4096 - 2048;
            1: return c * 200 - 700;
            2: return ((k + c) % 2 == 0) ? 2047 : -2048;
            default: return -(c * 37 + k * 5);
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int v [NCH];
        longint hold;
        for (int c = 0; c < NCH; c++) begin
            bg[c] = 0;
            for (int j = 0; j < WIN; j++) hist[c][j] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 reset total", longint'(total), 0);
        chk("R1 reset done", longint'(total_done), 0);
        chk("R1 reset valid", longint'(avg_valid), 0);

        // R1: gains reset to zero, so the first set gives zero
        for (int c = 0; c < NCH; c++) v[c] = 1000 + c;
        run_set(v, "R1 zero gain");

        for (int c = 0; c < NCH; c++) write_gain(c, 16 * (c + 1));

        // R2 R4: ramp-up, valid rise and window turnover over mixed patterns
        for (int k = 0; k < 24; k++) begin
            for (int c = 0; c < NCH; c++) v[c] = pat(k % 4, c, k);
            run_set(v, "R2 R4 pattern");
        end

        // R3: each gain isolated in turn
        for (int c = 0; c < NCH; c++) begin
            for (int x = 0; x < NCH; x++) write_gain(x, (x == c) ? (37 + 61 * c) : 0);
            for (int x = 0; x < NCH; x++) v[x] = pat(0, x, c + 50);
            run_set(v, "R3 single gain");
        end

        // R6 R8: a gain write does not move the total before the next update
        hold = longint'($signed(total));
        write_gain(3, 1023);
        repeat (10) @(negedge clk);
        chk("R8 total unchanged after gain write", longint'($signed(total)), hold);
        chk("R6 no done while idle", longint'(total_done), 0);
        for (int x = 0; x < NCH; x++) v[x] = 300;
        run_set(v, "R8 new gain applied");

        // R4: saturation at both limits
        for (int c = 0; c < NCH; c++) write_gain(c, 1023);
        for (int k = 0; k < WIN; k++) begin
            for (int c = 0; c < NCH; c++) v[c] = 2047;
            run_set(v, "R4 positive saturation");
        end
        chk("R4 max value", longint'($signed(total)), 32767);
        for (int k = 0; k < WIN; k++) begin
            for (int c = 0; c < NCH; c++) v[c] = -2048;
            run_set(v, "R4 negative saturation");
        end
        chk("R4 min value", longint'($signed(total)), -32768);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule